// File: doc/BRIEF.md
# I2C Interrupt Status and Clear Unit

This block gathers the event flags of an I2C controller into one interrupt picture. Most events are single-cycle pulses from the bus engine and the FIFOs, such as start or stop seen, abort, overflow, underflow, read request, done, activity and general call. The block latches these pulses and holds them until software clears them. Two flags are different: they are not latched but follow the FIFO fill levels. One compares the receive level with a programmable receive threshold, and the other compares the transmit level with a programmable transmit threshold.

The raw status is ANDed with a mask register to give the masked status. The OR of the masked bits drives a single interrupt line. Software clears latched events through side-effect reads. Each clearable event has its own clear address, and one combined-clear address clears all of them in one read. A small register port holds the mask and the two thresholds and returns read data one cycle after the request.

Top module: `i2c_irq_unit`

## Requirements
- R1: Raw status bit positions are: 0 rx underflow, 1 rx overflow, 2 rx full, 3 tx overflow, 4 tx empty, 5 read request, 6 tx abort, 7 rx done, 8 activity, 9 stop, 10 start, 11 general call. Reading word address 0 returns the raw status in bits 11:0.
- R2: Raw bit 2 is 1 exactly while `rx_level` is greater than the receive threshold (word address 3, bits LVL_W-1:0).
- R3: Raw bit 4 is 1 exactly while `tx_level` is less than or equal to the transmit threshold (word address 4, bits LVL_W-1:0).
- R4: A pulse on `evt_pulse[i]` for a latched bit i (every bit except 2 and 4) sets raw bit i from the next cycle on, and the bit stays set until a clear read.
- R5: A read of address 16+i clears latched bit i only and returns, in bit 0, the value the bit had before the clear.
- R6: A read of address 5 clears every latched bit and returns, in bit 0, the OR of the latched bits before the clear.
- R7: Clear reads have no effect on raw bits 2 and 4.
- R8: A read of address 1 returns the raw status ANDed with the mask (address 2, bits 11:0). `irq` is 1 exactly when that masked value is nonzero, so a zero mask keeps `irq` low.
- R9: An event pulse in the same cycle as a read that clears its bit leaves the bit set.
- R10: After reset the latched bits, the mask and both thresholds are 0, and `irq` is 0.
- R11: A write to address 2, 3 or 4 updates the mask, the receive threshold or the transmit threshold. Writes to any other address change nothing. `rd_data` shows read data in the cycle after `rd_en` and is 0 in every other cycle.
- R12: Pulses on `evt_pulse[2]` and `evt_pulse[4]` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_pulse | input | 12 | Event pulses in raw-status bit order |
| rx_level | input | LVL_W | Receive FIFO fill level |
| tx_level | input | LVL_W | Transmit FIFO fill level |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write word address |
| wr_data | input | DATA_W | Register write data |
| rd_en | input | 1 | Register read strobe; clear addresses act on it |
| rd_addr | input | ADDR_W | Register read word address |
| rd_data | output | DATA_W | Registered read data |
| irq | output | 1 | OR of the masked status bits |

## Verification
The bench builds the unit with LVL_W=4, ADDR_W=5 and DATA_W=16. With these values every pair of FIFO level and threshold, 256 per direction, can be swept. This makes it possible to check the greater-than and the at-or-below comparisons at every boundary. Each latched bit is set and cleared on its own address. The bench also covers a combined clear, a partial clear and a clear that coincides with its own event, and it steps through a set of masks against a known raw pattern.

// File: rtl/i2c_irq_pkg.sv
// Shared constants for the I2C interrupt unit: event bit positions,
// the set of latched bits and the word address map of the register port.
package i2c_irq_pkg;
    localparam int EVT_N = 12;

    localparam int B_RX_UF    = 0;
    localparam int B_RX_OF    = 1;
    localparam int B_RX_FULL  = 2;
    localparam int B_TX_OF    = 3;
    localparam int B_TX_EMPTY = 4;
    localparam int B_RD_REQ   = 5;
    localparam int B_TX_ABT   = 6;
    localparam int B_RX_DONE  = 7;
    localparam int B_ACT      = 8;
    localparam int B_STOP     = 9;
    localparam int B_START    = 10;
    localparam int B_GCALL    = 11;

    // Bits that are latched from pulses; the two level bits are excluded.
    localparam logic [EVT_N-1:0] LATCH_MASK =
        ~((EVT_N'(1) << B_RX_FULL) | (EVT_N'(1) << B_TX_EMPTY));

    // Word address map.
    localparam int A_RAW      = 0;
    localparam int A_MASKED   = 1;
    localparam int A_MASK     = 2;
    localparam int A_RX_THR   = 3;
    localparam int A_TX_THR   = 4;
    localparam int A_CLR_ALL  = 5;
    localparam int A_CLR_BASE = 16;
endpackage

// File: rtl/irq_level_flags.sv
// Level-derived flags: compares FIFO fill levels with their thresholds.
// Assumes levels and thresholds share the same unsigned width.
module irq_level_flags #(
    parameter int LVL_W = 7
) (
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] tx_level,
    input  logic [LVL_W-1:0] rx_thr,
    input  logic [LVL_W-1:0] tx_thr,
    output logic             rx_full,
    output logic             tx_empty
);
    // Receive side asks for service once the level passes its threshold.
    assign rx_full  = (rx_level > rx_thr);
    // Transmit side asks for data once the level falls to its threshold.
    assign tx_empty = (tx_level <= tx_thr);
endmodule

// File: rtl/irq_event_latch.sv
// Bank of sticky event flags. Each bit selected in KEEP is set by a pulse,
// cleared by a clear strobe, and a set wins over a clear in the same cycle.
// Bits not selected in KEEP are tied to zero.
module irq_event_latch #(
    parameter int             N    = 12,
    parameter logic [N-1:0]   KEEP = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flags_o
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        if (KEEP[g]) begin : g_keep
            logic flag_q;
            // Hold the flag; a new event takes priority over a clear.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    flag_q <= 1'b0;
                else if (set_i[g])
                    flag_q <= 1'b1;
                else if (clr_i[g])
                    flag_q <= 1'b0;
            end
            assign flags_o[g] = flag_q;
        end else begin : g_tie
            assign flags_o[g] = 1'b0;
        end
    end
endmodule

// File: rtl/irq_reg_port.sv
// Register port of the interrupt unit: holds the mask and the two
// thresholds, decodes reads, produces the clear strobes, and registers
// read data for one cycle. Assumes ADDR_W >= 5 and DATA_W > EVT_N >= LVL_W.
module irq_reg_port
    import i2c_irq_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 16,
    parameter int LVL_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [EVT_N-1:0]  raw_i,
    input  logic [EVT_N-1:0]  latched_i,
    output logic [EVT_N-1:0]  mask_o,
    output logic [LVL_W-1:0]  rx_thr_o,
    output logic [LVL_W-1:0]  tx_thr_o,
    output logic [EVT_N-1:0]  clr_o,
    output logic [DATA_W-1:0] rd_data_o
);
    logic [DATA_W-1:0] rd_next;
    logic              unused_hi;

    assign unused_hi = ^wr_data[DATA_W-1:EVT_N];

    // Configuration registers written through the port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_o   <= '0;
            rx_thr_o <= '0;
            tx_thr_o <= '0;
        end else if (wr_en) begin
            if (wr_addr == ADDR_W'(A_MASK))
                mask_o <= wr_data[EVT_N-1:0];
            if (wr_addr == ADDR_W'(A_RX_THR))
                rx_thr_o <= wr_data[LVL_W-1:0];
            if (wr_addr == ADDR_W'(A_TX_THR))
                tx_thr_o <= wr_data[LVL_W-1:0];
        end
    end

    // Clear strobes from per-bit and combined clear reads.
    always_comb begin
        clr_o = '0;
        if (rd_en) begin
            if (rd_addr == ADDR_W'(A_CLR_ALL))
                clr_o = LATCH_MASK;
            for (int i = 0; i < EVT_N; i++) begin
                if (rd_addr == ADDR_W'(A_CLR_BASE + i))
                    clr_o[i] = LATCH_MASK[i];
            end
        end
    end

    // Read data selection, taken before any clear lands.
    always_comb begin
        rd_next = '0;
        if (rd_addr == ADDR_W'(A_RAW))
            rd_next[EVT_N-1:0] = raw_i;
        else if (rd_addr == ADDR_W'(A_MASKED))
            rd_next[EVT_N-1:0] = raw_i & mask_o;
        else if (rd_addr == ADDR_W'(A_MASK))
            rd_next[EVT_N-1:0] = mask_o;
        else if (rd_addr == ADDR_W'(A_RX_THR))
            rd_next[LVL_W-1:0] = rx_thr_o;
        else if (rd_addr == ADDR_W'(A_TX_THR))
            rd_next[LVL_W-1:0] = tx_thr_o;
        else if (rd_addr == ADDR_W'(A_CLR_ALL))
            rd_next[0] = |latched_i;
        else begin
            for (int i = 0; i < EVT_N; i++) begin
                if (rd_addr == ADDR_W'(A_CLR_BASE + i))
                    rd_next[0] = latched_i[i];
            end
        end
    end

    // Registered read data, zero in cycles without a read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data_o <= '0;
        else
            rd_data_o <= rd_en ? rd_next : '0;
    end
endmodule

// File: rtl/i2c_irq_unit.sv
// I2C interrupt status and clear unit. Latches event pulses, derives the
// FIFO threshold flags, masks the result and drives one interrupt line.
// Assumes event pulses are synchronous to clk.
module i2c_irq_unit
    import i2c_irq_pkg::*;
#(
    parameter int LVL_W  = 7,
    parameter int ADDR_W = 5,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [11:0]       evt_pulse,
    input  logic [LVL_W-1:0]  rx_level,
    input  logic [LVL_W-1:0]  tx_level,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq
);
    logic [EVT_N-1:0] latched_q;
    logic [EVT_N-1:0] clr_vec;
    logic [EVT_N-1:0] mask_q;
    logic [EVT_N-1:0] raw_stat;
    logic [LVL_W-1:0] rx_thr_q;
    logic [LVL_W-1:0] tx_thr_q;
    logic             rx_full;
    logic             tx_empty;

    irq_level_flags #(.LVL_W(LVL_W)) u_levels (
        .rx_level (rx_level),
        .tx_level (tx_level),
        .rx_thr   (rx_thr_q),
        .tx_thr   (tx_thr_q),
        .rx_full  (rx_full),
        .tx_empty (tx_empty)
    );

    irq_event_latch #(.N(EVT_N), .KEEP(LATCH_MASK)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (evt_pulse),
        .clr_i   (clr_vec),
        .flags_o (latched_q)
    );

    // Raw status: latched events plus the two live level flags.
    always_comb begin
        raw_stat             = latched_q;
        raw_stat[B_RX_FULL]  = rx_full;
        raw_stat[B_TX_EMPTY] = tx_empty;
    end

    irq_reg_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LVL_W(LVL_W)) u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .raw_i     (raw_stat),
        .latched_i (latched_q),
        .mask_o    (mask_q),
        .rx_thr_o  (rx_thr_q),
        .tx_thr_o  (tx_thr_q),
        .clr_o     (clr_vec),
        .rd_data_o (rd_data)
    );

    // Interrupt line: any enabled status bit.
    assign irq = |(raw_stat & mask_q);
endmodule

// File: rtl/i2c_irq_chk.sv
// Checker for the interrupt unit; attached to every instance by bind.
module i2c_irq_chk
    import i2c_irq_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [11:0]       evt_pulse,
    input logic              rd_en,
    input logic [DATA_W-1:0] rd_data,
    input logic              irq,
    input logic [EVT_N-1:0]  mask_q,
    input logic [EVT_N-1:0]  latched_q,
    input logic [EVT_N-1:0]  clr_vec
);
    // R8: with nothing enabled the line stays low.
    p_zero_mask_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq);

    // R4: a set flag with no clear stays set.
    p_flag_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((latched_q & $past(latched_q & ~clr_vec)) == $past(latched_q & ~clr_vec)));

    // R9: an event always lands, even under a clear.
    p_event_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((latched_q & $past(evt_pulse & LATCH_MASK)) == $past(evt_pulse & LATCH_MASK)));

    // R5: a clear without a coinciding event empties the bit.
    p_clear_takes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((latched_q & $past(clr_vec & ~evt_pulse)) == '0));

    // R11: read data is zero after a cycle without a read.
    p_rdata_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (rd_data == '0));
endmodule

bind i2c_irq_unit i2c_irq_chk #(.DATA_W(DATA_W)) u_irq_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_pulse (evt_pulse),
    .rd_en     (rd_en),
    .rd_data   (rd_data),
    .irq       (irq),
    .mask_q    (mask_q),
    .latched_q (latched_q),
    .clr_vec   (clr_vec)
);

// File: tb/test_i2c_irq_unit.sv
`timescale 1ns/1ps
// Bench for the interrupt unit built with 4-bit levels; sweeps every
// level/threshold pair and every latched bit.
module test_i2c_irq_unit;
    localparam int LVL_W  = 4;
    localparam int ADDR_W = 5;
    localparam int DATA_W = 16;
    localparam int CLR0   = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [11:0]       evt_pulse = '0;
    logic [LVL_W-1:0]  rx_level = '0;
    logic [LVL_W-1:0]  tx_level = '0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              rd_en = 1'b0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [DATA_W-1:0] rd_data;
    logic              irq;

    int checks = 0;
    int fails  = 0;
    logic [DATA_W-1:0] got;

    always #4 clk = ~clk;

    i2c_irq_unit #(.LVL_W(LVL_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_i2c_irq_unit (
        .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse),
        .rx_level(rx_level), .tx_level(tx_level),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_read(input int addr, output logic [DATA_W-1:0] d);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = ADDR_W'(addr);
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic do_write(input int addr, input int data);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = ADDR_W'(addr); wr_data = DATA_W'(data);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse(input logic [11:0] v);
        @(negedge clk);
        evt_pulse = v;
        @(negedge clk);
        evt_pulse = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R10: reset state; levels 0, thresholds 0 give tx empty only.
        chk("R10 irq", 32'(irq), 0);
        do_read(0, got);      chk("R10 raw", 32'(got), 32'h010);
        do_read(2, got);      chk("R10 mask", 32'(got), 0);
        do_read(3, got);      chk("R10 rxthr", 32'(got), 0);
        do_read(4, got);      chk("R10 txthr", 32'(got), 0);

        // R11: register writes, ignored address, idle read data.
        do_write(2, 16'hFA5A);
        do_read(2, got);      chk("R11 mask", 32'(got), 32'hA5A);
        @(negedge clk);       chk("R11 idle", 32'(rd_data), 0);
        do_write(6, 16'hFFFF);
        do_write(31, 16'hFFFF);
        do_read(2, got);      chk("R11 mask kept", 32'(got), 32'hA5A);
        do_read(3, got);      chk("R11 rxthr kept", 32'(got), 0);
        do_read(4, got);      chk("R11 txthr kept", 32'(got), 0);
        do_write(3, 9);
        do_read(3, got);      chk("R11 rxthr", 32'(got), 9);
        do_write(4, 7);
        do_read(4, got);      chk("R11 txthr", 32'(got), 7);
        do_write(2, 0);

        // R2: receive level above threshold, every pair.
        tx_level = 4'd15; do_write(4, 0);
        for (int t = 0; t < 16; t++) begin
            do_write(3, t);
            for (int l = 0; l < 16; l++) begin
                rx_level = 4'(l);
                do_read(0, got);
                chk("R2 rxfull", 32'(got), (l > t) ? 32'h004 : 32'h000);
            end
        end

        // R3: transmit level at or below threshold, every pair.
        rx_level = 0; do_write(3, 0);
        for (int t = 0; t < 16; t++) begin
            do_write(4, t);
            for (int l = 0; l < 16; l++) begin
                tx_level = 4'(l);
                do_read(0, got);
                chk("R3 txempty", 32'(got), (l <= t) ? 32'h010 : 32'h000);
            end
        end

        // Neutral levels: both level flags 0.
        rx_level = 0; tx_level = 4'd15; do_write(3, 0); do_write(4, 0);

        // R1, R4, R5: each latched bit alone.
        for (int i = 0; i < 12; i++) begin
            if (i != 2 && i != 4) begin
                pulse(12'(1) << i);
                repeat (2) @(negedge clk);
                do_read(0, got);        chk("R1 R4 bit set", 32'(got), 32'(1) << i);
                do_read(CLR0 + i, got); chk("R5 clear returns", 32'(got), 1);
                do_read(0, got);        chk("R5 cleared", 32'(got), 0);
            end
        end

        // R5: one clear leaves the other bits.
        pulse(12'hFFF);
        do_read(CLR0 + 3, got); chk("R5 partial ret", 32'(got), 1);
        do_read(0, got);        chk("R5 others kept", 32'(got), 32'hFE3);

        // R6: combined clear.
        do_read(5, got);        chk("R6 ret", 32'(got), 1);
        do_read(0, got);        chk("R6 all clear", 32'(got), 0);
        do_read(5, got);        chk("R6 empty ret", 32'(got), 0);

        // R12: level-bit pulses ignored.
        pulse(12'h014);
        do_read(0, got);        chk("R12 ignored", 32'(got), 0);
        do_read(CLR0 + 2, got); chk("R12 clr2 ret", 32'(got), 0);

        // R7: clears leave level flags alone.
        rx_level = 4'd5; tx_level = 0;
        pulse(12'h001);
        do_read(5, got);        chk("R7 ret", 32'(got), 1);
        do_read(0, got);        chk("R7 levels kept", 32'(got), 32'h014);
        do_read(CLR0 + 4, got);
        do_read(CLR0 + 2, got);
        do_read(0, got);        chk("R7 per-bit", 32'(got), 32'h014);
        tx_level = 4'd15;

        // R8: masking; raw = 0x0C1 events + rx full = 0x0C5.
        pulse(12'h0C1);
        begin
            logic [11:0] ml [6] = '{12'h000, 12'h001, 12'h040, 12'h100, 12'hFFF, 12'h004};
            for (int k = 0; k < 6; k++) begin
                do_write(2, 32'(ml[k]));
                do_read(1, got);
                chk("R8 masked", 32'(got), 32'(12'h0C5 & ml[k]));
                chk("R8 irq", 32'(irq), 32'(|(12'h0C5 & ml[k])));
            end
        end
        do_write(2, 0);
        rx_level = 0;

        // R9: event coinciding with its per-bit clear.
        do_read(5, got);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = ADDR_W'(CLR0 + 9); evt_pulse = 12'h200;
        @(negedge clk);
        rd_en = 1'b0; evt_pulse = '0;
        chk("R9 ret", 32'(rd_data), 0);
        do_read(0, got);        chk("R9 per-bit set", 32'(got), 32'h200);

        // R9: event coinciding with a combined clear.
        pulse(12'h001);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = ADDR_W'(5); evt_pulse = 12'h800;
        @(negedge clk);
        rd_en = 1'b0; evt_pulse = '0;
        chk("R9 all ret", 32'(rd_data), 1);
        do_read(0, got);        chk("R9 all set", 32'(got), 32'h800);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule